// File: doc/BRIEF.md
# Byte CPU fetch-execute sequencer

This block is the control core of a small 8-bit processor. It holds four 8-bit general registers, a 16-bit program counter, a 16-bit stack pointer, four condition flags and a halt bit. It walks a byte-wide synchronous RAM through fetch, operand read, execute and write-back, one instruction at a time. Every instruction starts with a 16-bit word. The upper nibble selects the operation, bits 11:10 name the destination register, bits 9:8 name the source register and the low byte is unused. Memory and branch operations carry a further big-endian 16-bit address after that word.

The RAM port is a plain fixed-latency interface, not a valid/ready stream. The sequencer asserts a read strobe with an address, and the RAM must present the byte on the following cycle. A write strobe with address and data commits in the same cycle. The RAM has no way to stall the core, so no back-pressure exists. The core keeps the request address stable for the cycle in which it is issued and captures the returned byte on the next edge. The cycle counter, halt status, register, flag, PC and SP outputs are plain status pins. A bench or system monitor uses them to compare the final machine state after a fixed program.

Top module: `byte_cpu_seq`

## Requirements
- R1: While `rst_n` is low and right after reset, PC equals `RESET_PC`, SP equals `RESET_SP`, all registers and flags read 0, `halted` is 0 and `cycle_count` is 0.
- R2: The instruction word is read as two bytes, the high byte from PC and the low byte from PC+1 (16-bit wrap). Read data is taken one cycle after `mem_rd`. `mem_rd` and `mem_we` are never high together.
- R3: Opcodes 0x0 ADD, 0x1 SUB, 0x2 AND, 0x3 OR, 0x4 XOR, 0x5 shift-left, 0x6 shift-right, 0x7 MUL (low byte) and 0x8 DIV (quotient) write their 8-bit result into the destination register. The shifts act on the destination register only. PC then advances by 2.
- R4: `flags_o` is {Z,N,C,V} from bit 3 down to bit 0. Z means a zero result and N is result bit 7. For ADD, C is the carry out and V is the signed overflow. For SUB and CMP, C means the minuend is at least the subtrahend and V is the signed overflow. For the shifts, C is the bit shifted out. For MUL, C means the product exceeds 255. For AND, OR, XOR and nonzero DIV, C and V are 0.
- R5: DIV by a zero source register gives result 0 with Z=1, C=1 and V=1.
- R6: CMP (0x9) sets flags as SUB does and leaves the destination register unchanged.
- R7: LOAD (0xA) copies the byte at the 16-bit operand address into the destination register, with Z and N from that byte and C=V=0. STORE (0xB) writes the source register to the operand address and changes no register. Both advance PC by 4.
- R8: JMP (0xC) sets PC to the operand. JZ (0xD) sets PC to the operand when Z is 1 and otherwise to PC+4.
- R9: CALL (0xE) writes the high byte of PC+4 to SP-1, then the low byte to SP-2. It leaves SP two lower and PC at the operand.
- R10: STORE, JMP, JZ, CALL and HALT leave the flags unchanged.
- R11: HALT (0xF) sets `halted` and moves PC past itself by 2. From then on, no PC, SP, register, flag or counter change and no memory access happens until reset.
- R12: `cycle_count` advances once per clock while `halted` is 0. An instruction costs 4 cycles for opcodes 0x0–0x9 and 0xF, 6 for STORE, JMP and JZ, and 7 for LOAD and CALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | RAM byte address |
| mem_rd | output | 1 | Read request; data expected next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| halted | output | 1 | Halt bit |
| cycle_count | output | CNT_W | Clocks spent while running |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 4 | {Z,N,C,V} |
| regs_o | output | 32 | Register k at bits 8k+7:8k |

## Verification
The arithmetic path is driven by a table of operand pairs. Each pair is loaded from memory and combined by one operation. The pairs are chosen so that each flag is separated from its neighbours: signed overflow without a carry, a carry with a zero result, a borrow with a negative result, and a divide by zero against an ordinary quotient. A nonzero source beside a shift shows the source is ignored. Two equal operands in a compare show the destination is untouched. A control-flow program takes JZ one way and then the other, calls through the stack, jumps over halts and stores to memory. The final registers, RAM bytes, SP, PC and cycle total then show both the path taken and its cost. A last program sets N, runs flag-preserving opcodes and then idles after HALT, which shows that no state or bus activity moves.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DW     = 8;
  localparam int AW     = 16;
  localparam int NREG   = 4;
  localparam int RSEL_W = $clog2(NREG);
  localparam int OPC_W  = 4;
  localparam int IW     = 2 * DW;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 4'h0, OP_SUB  = 4'h1, OP_AND  = 4'h2, OP_OR   = 4'h3,
    OP_XOR   = 4'h4, OP_SHL  = 4'h5, OP_SHR  = 4'h6, OP_MUL  = 4'h7,
    OP_DIV   = 4'h8, OP_CMP  = 4'h9, OP_LOAD = 4'hA, OP_STORE = 4'hB,
    OP_JMP   = 4'hC, OP_JZ   = 4'hD, OP_CALL = 4'hE, OP_HALT = 4'hF
  } opcode_e;

  typedef enum logic [3:0] {
    ST_F0, ST_F1, ST_F2, ST_A1, ST_A2, ST_EX, ST_LD, ST_PUSH, ST_HALT
  } seq_state_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  function automatic logic needs_operand(opcode_e op);
    return (op >= OP_LOAD) && (op <= OP_CALL);
  endfunction

  function automatic logic is_arith(opcode_e op);
    return op <= OP_CMP;
  endfunction
endpackage

// File: rtl/byte_alu.sv
module byte_alu
  import cpu_pkg::*;
(
  input  opcode_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          carry,
  output logic          ovf
);
  localparam int MSB = DW - 1;

  logic [DW:0]     sum;
  logic [DW:0]     dif;
  logic [2*DW-1:0] prod;

  always_comb begin
    sum   = {1'b0, a} + {1'b0, b};
    dif   = {1'b0, a} - {1'b0, b};
    prod  = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    res   = a;
    carry = 1'b0;
    ovf   = 1'b0;
    case (op)
      OP_ADD: begin
        res   = sum[DW-1:0];
        carry = sum[DW];
        ovf   = (a[MSB] ^ res[MSB]) & (b[MSB] ^ res[MSB]);
      end
      OP_SUB, OP_CMP: begin
        res   = dif[DW-1:0];
        carry = (a >= b);
        ovf   = (a[MSB] ^ b[MSB]) & (a[MSB] ^ res[MSB]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SHL: begin
        res   = {a[DW-2:0], 1'b0};
        carry = a[MSB];
      end
      OP_SHR: begin
        res   = {1'b0, a[DW-1:1]};
        carry = a[0];
      end
      OP_MUL: begin
        res   = prod[DW-1:0];
        carry = |prod[2*DW-1:DW];
      end
      OP_DIV: begin
        if (b == '0) begin
          res   = '0;
          carry = 1'b1;
          ovf   = 1'b1;
        end else begin
          res = a / b;
        end
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] rsel_a,
  input  logic [SW-1:0] rsel_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  output logic [N*W-1:0] flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= '0;
      else if (we && (wsel == SW'(g)))    q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  assign rdata_a = flat[rsel_a*W +: W];
  assign rdata_b = flat[rsel_b*W +: W];

  // R3: a write is visible in the selected register on the next cycle
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (flat[$past(wsel)*W +: W] == $past(wdata)));
endmodule

// File: rtl/cpu_cycle_ctr.sv
module cpu_cycle_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count + 1'b1;
  end

  assert_count_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
  assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count == CW'($past(count) + 1'b1)));
endmodule

// File: rtl/byte_cpu_seq.sv
module byte_cpu_seq
  import cpu_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [15:0] RESET_SP = 16'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_we,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               halted,
  output logic [CNT_W-1:0]   cycle_count,
  output logic [AW-1:0]      pc_o,
  output logic [AW-1:0]      sp_o,
  output logic [3:0]         flags_o,
  output logic [NREG*DW-1:0] regs_o
);
  seq_state_e       st_q;
  logic [AW-1:0]    pc_q, sp_q, opnd_q;
  logic [IW-1:0]    ir_q;
  flags_t           flg_q;
  logic             halt_q;

  opcode_e          op;
  logic [RSEL_W-1:0] rd_sel, rs_sel;
  logic [AW-1:0]    pc_p1, pc_p2, pc_p3, pc_p4, sp_m1;
  logic [DW-1:0]    ra, rb, alu_res;
  logic             alu_c, alu_v;
  logic             rf_we;
  logic [DW-1:0]    rf_wdata;

  assign op     = opcode_e'(ir_q[IW-1 -: OPC_W]);
  assign rd_sel = ir_q[IW-OPC_W-1 -: RSEL_W];
  assign rs_sel = ir_q[IW-OPC_W-RSEL_W-1 -: RSEL_W];
  assign pc_p1  = pc_q + AW'(1);
  assign pc_p2  = pc_q + AW'(2);
  assign pc_p3  = pc_q + AW'(3);
  assign pc_p4  = pc_q + AW'(4);
  assign sp_m1  = sp_q - AW'(1);

  byte_alu u_alu (
    .op    (op),
    .a     (ra),
    .b     (rb),
    .res   (alu_res),
    .carry (alu_c),
    .ovf   (alu_v)
  );

  assign rf_we    = ((st_q == ST_EX) && (op <= OP_DIV)) || (st_q == ST_LD);
  assign rf_wdata = (st_q == ST_LD) ? mem_rdata : alu_res;

  cpu_regfile #(.N(NREG), .W(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .wsel    (rd_sel),
    .wdata   (rf_wdata),
    .rsel_a  (rd_sel),
    .rsel_b  (rs_sel),
    .rdata_a (ra),
    .rdata_b (rb),
    .flat    (regs_o)
  );

  cpu_cycle_ctr #(.CW(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!halt_q),
    .count (cycle_count)
  );

  // memory request decode: one request per cycle, address held for its cycle
  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (st_q)
      ST_F0: begin mem_addr = pc_q;  mem_rd = 1'b1; end
      ST_F1: begin mem_addr = pc_p1; mem_rd = 1'b1; end
      ST_F2: if (needs_operand(op)) begin mem_addr = pc_p2; mem_rd = 1'b1; end
      ST_A1: begin mem_addr = pc_p3; mem_rd = 1'b1; end
      ST_EX: begin
        case (op)
          OP_LOAD:  begin mem_addr = opnd_q; mem_rd = 1'b1; end
          OP_STORE: begin mem_addr = opnd_q; mem_we = 1'b1; mem_wdata = rb; end
          OP_CALL:  begin mem_addr = sp_m1;  mem_we = 1'b1; mem_wdata = pc_p4[AW-1 -: DW]; end
          default: ;
        endcase
      end
      ST_PUSH: begin mem_addr = sp_m1; mem_we = 1'b1; mem_wdata = pc_p4[DW-1:0]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_F0;
      pc_q   <= RESET_PC;
      sp_q   <= RESET_SP;
      ir_q   <= '0;
      opnd_q <= '0;
      flg_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      case (st_q)
        ST_F0: st_q <= ST_F1;
        ST_F1: begin
          ir_q[IW-1 -: DW] <= mem_rdata;
          st_q             <= ST_F2;
        end
        ST_F2: begin
          ir_q[DW-1:0] <= mem_rdata;
          st_q         <= needs_operand(op) ? ST_A1 : ST_EX;
        end
        ST_A1: begin
          opnd_q[AW-1 -: DW] <= mem_rdata;
          st_q               <= ST_A2;
        end
        ST_A2: begin
          opnd_q[DW-1:0] <= mem_rdata;
          st_q           <= ST_EX;
        end
        ST_EX: begin
          st_q <= ST_F0;
          case (op)
            OP_LOAD:  st_q <= ST_LD;
            OP_STORE: pc_q <= pc_p4;
            OP_JMP:   pc_q <= opnd_q;
            OP_JZ:    pc_q <= flg_q.z ? opnd_q : pc_p4;
            OP_CALL: begin
              sp_q <= sp_m1;
              st_q <= ST_PUSH;
            end
            OP_HALT: begin
              halt_q <= 1'b1;
              pc_q   <= pc_p2;
              st_q   <= ST_HALT;
            end
            default: begin
              flg_q <= flags_t'{z: (alu_res == '0), n: alu_res[DW-1], c: alu_c, v: alu_v};
              pc_q  <= pc_p2;
            end
          endcase
        end
        ST_LD: begin
          flg_q <= flags_t'{z: (mem_rdata == '0), n: mem_rdata[DW-1], c: 1'b0, v: 1'b0};
          pc_q  <= pc_p4;
          st_q  <= ST_F0;
        end
        ST_PUSH: begin
          sp_q <= sp_m1;
          pc_q <= opnd_q;
          st_q <= ST_F0;
        end
        ST_HALT: st_q <= ST_HALT;
        default: st_q <= ST_F0;
      endcase
    end
  end

  assign halted  = halt_q;
  assign pc_o    = pc_q;
  assign sp_o    = sp_q;
  assign flags_o = flg_q;

  // R2: bus never reads and writes at once
  assert_rd_we_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));
  // R2: low instruction byte is fetched from the address after the high byte
  assert_fetch_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_F1) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));
  // R9: second push goes one below the first
  assert_push_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH) |-> (mem_addr == AW'($past(mem_addr) - 1'b1)));
  // R10: flag-preserving opcodes leave flags alone
  assert_flags_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_EX) && !is_arith(op)) |=> $stable(flg_q));
  // R11: once halted, state and bus are frozen
  assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(pc_q) && $stable(sp_q) && $stable(flg_q)
                && $stable(regs_o) && !mem_rd && !mem_we));
endmodule

// File: tb/byte_cpu_seq_bench.sv
`timescale 1ns/1ps
module byte_cpu_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        halted;
  logic [31:0] cycle_count;
  logic [15:0] pc_o, sp_o;
  logic [3:0]  flags_o;
  logic [31:0] regs_o;

  always #2.5 clk = ~clk;

  byte_cpu_seq u_byte_cpu_seq (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
    .cycle_count(cycle_count), .pc_o(pc_o), .sp_o(sp_o), .flags_o(flags_o), .regs_o(regs_o)
  );

  // byte RAM, 256 bytes aliased over the address space
  logic [7:0] mem [256];
  logic       clr, ld_en;
  logic [7:0] ld_a, ld_d;
  int         halt_access = 0;
  int         bus_clash = 0;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (ld_en) begin
      mem[ld_a] <= ld_d;
    end else if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (rst_n && halted && (mem_rd || mem_we)) halt_access++;
    if (rst_n && mem_rd && mem_we) bus_clash++;
  end

  int nchk = 0;
  int nerr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_a = a; ld_d = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put_word(input logic [7:0] a, input logic [7:0] hi);
    poke(a, hi);
    poke(a + 8'd1, 8'h00);
  endtask

  task automatic put_long(input logic [7:0] a, input logic [7:0] hi, input logic [15:0] tgt);
    put_word(a, hi);
    poke(a + 8'd2, tgt[15:8]);
    poke(a + 8'd3, tgt[7:0]);
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run_to_halt(input string req);
    int n;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, halted}, 32'd1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  // {opcode, a, b, expected r0, expected flags ZNCV}
  localparam int NVEC = 15;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0_7F_01_80_5, 32'h0_FF_01_00_A, 32'h1_05_07_FE_4, 32'h1_80_01_7F_3,
    32'h2_F0_0F_00_8, 32'h3_F0_0F_FF_4, 32'h4_AA_AA_00_8, 32'h5_81_55_02_2,
    32'h6_03_00_01_2, 32'h7_10_10_00_A, 32'h7_03_05_0F_0, 32'h8_64_07_0E_0,
    32'h8_09_00_00_B, 32'h9_05_05_05_A, 32'h9_03_09_03_4
  };

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: actual hung expected halt");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; ld_en = 1'b0; ld_a = '0; ld_d = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 pc", {16'd0, pc_o}, 32'h0);
    check("R1 sp", {16'd0, sp_o}, 32'h0);
    check("R1 regs", regs_o, 32'h0);
    check("R1 flags", {28'd0, flags_o}, 32'h0);
    check("R1 halted", {31'd0, halted}, 32'h0);
    check("R1 count", cycle_count, 32'h0);

    // arithmetic table: LOAD r0,[80]; LOAD r1,[81]; op r0,r1; HALT
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] vop;
      logic [7:0] va, vb, vr;
      logic [3:0] vf;
      string tag;
      {vop, va, vb, vr, vf} = VEC[i];
      tag = (vop == 4'h8 && vb == 8'h00) ? "R5" : (vop == 4'h9) ? "R6" : "R3";
      begin_prog();
      poke(8'h80, va);
      poke(8'h81, vb);
      put_long(8'h00, 8'hA0, 16'h0080);
      put_long(8'h04, 8'hA4, 16'h0081);
      put_word(8'h08, {vop, 4'b0001});
      put_word(8'h0A, 8'hF0);
      if (i == 0) begin
        @(negedge clk);
        rst_n = 1'b1;
        // R2: first fetch at PC, then PC+1
        check("R2 fetch hi addr", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h0000});
        @(negedge clk);
        check("R2 fetch lo addr", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h0001});
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
      end
      run_to_halt("R11 halt reached");
      check(tag, {24'd0, regs_o[7:0]}, {24'd0, vr});
      check("R4 flags", {28'd0, flags_o}, {28'd0, vf});
      check("R12 cycles", cycle_count, 32'd22);
      check("R3 pc", {16'd0, pc_o}, 32'h000C);
    end

    // control flow: STORE, JZ taken / not taken, CALL, JMP
    begin_prog();
    poke(8'h80, 8'h00);
    poke(8'h81, 8'h5A);
    poke(8'hFF, 8'hEE);
    put_long(8'h00, 8'hA4, 16'h0081);   // LOAD r1
    put_long(8'h04, 8'hB1, 16'h0090);   // STORE r1
    put_long(8'h08, 8'hA0, 16'h0080);   // LOAD r0 = 0 -> Z
    put_long(8'h0C, 8'hD0, 16'h0020);   // JZ taken
    put_word(8'h10, 8'hF0);             // skipped HALT
    put_long(8'h20, 8'hE0, 16'h0030);   // CALL
    put_long(8'h30, 8'hA8, 16'h0081);   // LOAD r2
    put_long(8'h34, 8'hD0, 16'h0010);   // JZ not taken
    put_long(8'h38, 8'hC0, 16'h0040);   // JMP
    put_word(8'h3C, 8'hF0);             // skipped HALT
    put_word(8'h40, 8'hF0);             // HALT
    run_to_halt("R8 halt reached");
    check("R7 store byte", {24'd0, mem[8'h90]}, 32'h5A);
    check("R7 load regs", regs_o, 32'h005A5A00);
    check("R8 pc path", {16'd0, pc_o}, 32'h0042);
    check("R9 push hi", {24'd0, mem[8'hFF]}, 32'h00);
    check("R9 push lo", {24'd0, mem[8'hFE]}, 32'h24);
    check("R9 sp", {16'd0, sp_o}, 32'hFFFE);
    check("R7 flags", {28'd0, flags_o}, 32'h0);
    check("R12 cycles", cycle_count, 32'd56);
    check("R2 bus clash", bus_clash, 0);

    // flags kept across STORE/JMP/HALT, then frozen after halt
    begin_prog();
    poke(8'h82, 8'h80);
    put_long(8'h00, 8'hA0, 16'h0082);
    put_long(8'h04, 8'hB0, 16'h0091);
    put_long(8'h08, 8'hC0, 16'h000C);
    put_word(8'h0C, 8'hF0);
    run_to_halt("R11 halt reached");
    check("R10 flags", {28'd0, flags_o}, 32'h4);
    check("R7 store byte", {24'd0, mem[8'h91]}, 32'h80);
    check("R11 pc past halt", {16'd0, pc_o}, 32'h000E);
    check("R12 cycles", cycle_count, 32'd23);
    halt_access = 0;
    repeat (20) @(negedge clk);
    check("R11 pc frozen", {16'd0, pc_o}, 32'h000E);
    check("R11 regs frozen", regs_o, 32'h00000080);
    check("R11 flags frozen", {28'd0, flags_o}, 32'h4);
    check("R12 count frozen", cycle_count, 32'd23);
    check("R11 no bus", halt_access, 0);

    summary();
    $finish;
  end
endmodule